// File: doc/BRIEF.md
# Exclusive Word Access Reservation Unit

This unit carries out word loads and word stores for a 32-bit core that has a load-reserve and store-conditional pair. It holds one reservation bit. An exclusive load sets the bit when its data returns from memory. A later exclusive store writes memory only while the bit is still set.

The result of an exclusive store is reported on a carry flag instead of a register:
- carry 0 means the store reached memory;
- carry 1 means the store was dropped.

Every exclusive store uses up the reservation. Any interrupt or exception also clears it. The reservation holds no address. Exclusive accesses are always word accesses at a word-aligned address, and a misaligned address is not a fault.

Ordinary loads and stores use the same memory port and never touch either flag. They may be byte, halfword or word accesses, with an optional byte-reversed mode.

The unit sits between instruction decode and a simple memory port. It takes one operation at a time.

All three data paths are valid/ready, with these back-pressure rules:
- **Operation input:** an operation is accepted only in a cycle where `op_valid` and `op_ready` are both high. `op_ready` is high only while no operation is in flight.
- **Memory request:** once `mem_req_valid` rises, every request field stays stable until `mem_req_ready` is seen.
- **Load result:** the result stays on `res_data` with `res_valid` high until `res_ready` is seen.
- **Memory response:** the response has no ready. `mem_rsp_valid` is taken in the cycle it is high, one response for each read request.

Top module: `excl_access_unit`

## Requirements
- R1: After reset, `carry_flag` is 0, `flag_word` is all zero, `op_ready` is 1, and `mem_req_valid` and `res_valid` are 0.
- R2: Bit 10 of `op_func` marks an operation as exclusive. Bit 9 selects byte-reversed access:
  - a reversed word swaps the byte order of the data;
  - a reversed halfword XORs address bits [1:0] with 2;
  - a reversed byte XORs address bits [1:0] with 3.
  Bit 9 alone does not make an operation exclusive.
- R3: An exclusive operation is always a word access, whatever `op_size` says. It is issued with address bits [1:0] forced to 0 and `mem_req_be` = 4'b1111, and raises no fault.
- R4: An exclusive load sets the reservation (`flag_word` bit 24) and clears `carry_flag` in the cycle its memory response is taken, not when the load is accepted.
- R5: An exclusive store accepted while the reservation is set, with no trap in that cycle, issues exactly one memory write and then leaves `carry_flag` = 0.
- R6: An exclusive store accepted while the reservation is clear, or in the same cycle as a trap, issues no memory request. `carry_flag` becomes 1 one cycle after acceptance.
- R7: Accepting any exclusive store clears the reservation. A second exclusive store with no exclusive load in between therefore fails.
- R8: While `trap_take` is high, the reservation is cleared in the next cycle. A trap that arrives while an exclusive load is in flight stops that load from setting the reservation.
- R9: Ordinary loads and stores leave `carry_flag` and the reservation unchanged.
- R10: A pending memory request holds `mem_req_valid` and all request fields stable until `mem_req_ready`. A pending result holds `res_valid` and `res_data` until `res_ready`.
- R11: Ordinary sub-word access works on little-endian lanes:
  - a byte store sets one enable bit, at `addr[1:0]`, and copies the byte to every lane;
  - a halfword store sets the two enables of the half at `addr[1]` and copies the half to both halves;
  - loaded bytes and halfwords are zero-extended;
  - ordinary accesses keep their byte address unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | Operation offered |
| op_ready | output | 1 | Unit idle and able to accept an operation |
| op_store | input | 1 | 1 = store, 0 = load |
| op_func | input | 11 | Low instruction bits: bit 10 exclusive, bit 9 byte-reversed |
| op_size | input | 2 | 0 byte, 1 halfword, 2 or 3 word |
| op_addr | input | 32 | Effective byte address |
| op_wdata | input | 32 | Store data |
| trap_take | input | 1 | Interrupt or exception being taken |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_write | output | 1 | 1 = write, 0 = read |
| mem_req_addr | output | 32 | Request byte address |
| mem_req_be | output | 4 | Byte-lane enables |
| mem_req_wdata | output | 32 | Write data placed on the byte lanes |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | 32 | Read data |
| res_valid | output | 1 | Load result valid |
| res_ready | input | 1 | Consumer takes the load result |
| res_data | output | 32 | Aligned, zero-extended load result |
| carry_flag | output | 1 | Exclusive outcome: 0 success or load done, 1 store dropped |
| flag_word | output | 32 | Internal flag state; bit 24 is the reservation |

## Verification
A reservation bit that is wrongly set or wrongly cleared never shows on the memory port by itself. It shows on the next exclusive store: a stuck-clear bit makes a store vanish and returns carry 1 one cycle after acceptance, and a stuck-set bit lets a second store write memory. The tests therefore pair every reservation-changing event (a trap, an exclusive store, an ordinary access) with a following exclusive store, and also read bit 24 of `flag_word` directly. A wrong lane or address decode shows up at the request handshake on `mem_req_addr` and `mem_req_be`, and in the word read back one load later.

// File: rtl/excl_pkg.sv
package excl_pkg;

  localparam logic [1:0] SZ_BYTE = 2'd0;
  localparam logic [1:0] SZ_HALF = 2'd1;
  localparam logic [1:0] SZ_WORD = 2'd2;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_REQ  = 2'd1,
    ST_RSP  = 2'd2,
    ST_RES  = 2'd3
  } seq_state_e;

  typedef struct packed {
    logic       store;
    logic       excl;
    logic       rev;
    logic [1:0] size;
  } op_attr_t;

endpackage

// File: rtl/excl_decode.sv
module excl_decode
  import excl_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int DATA_W   = 32,
  parameter int FUNC_W   = 11,
  parameter int EXCL_BIT = 10,
  parameter int REV_BIT  = 9
) (
  input  logic                op_store,
  input  logic [FUNC_W-1:0]   op_func,
  input  logic [1:0]          op_size,
  input  logic [ADDR_W-1:0]   op_addr,
  input  logic [DATA_W-1:0]   op_wdata,
  output op_attr_t            attr,
  output logic [ADDR_W-1:0]   eff_addr,
  output logic [DATA_W/8-1:0] lane_be,
  output logic [DATA_W-1:0]   lane_wdata
);
  localparam int BYTES = DATA_W / 8;
  localparam int LSB_W = $clog2(BYTES);
  localparam int HALFS = BYTES / 2;
  localparam logic [LSB_W-1:0] LO_ALL  = '1;
  localparam logic [LSB_W-1:0] LO_HALF = {{(LSB_W-1){1'b1}}, 1'b0};

  logic             is_excl;
  logic             is_rev;
  logic [1:0]       eff_size;
  logic [LSB_W-1:0] lo_in;
  logic [LSB_W-1:0] lo_out;
  logic [DATA_W-1:0] swapped;
  logic             func_unused;

  assign is_excl     = op_func[EXCL_BIT];
  assign is_rev      = op_func[REV_BIT];
  assign func_unused = ^op_func;
  assign lo_in       = op_addr[LSB_W-1:0];

  always_comb begin
    if (is_excl || op_size == 2'd3) eff_size = SZ_WORD;
    else                            eff_size = op_size;
  end

  assign attr = '{store: op_store, excl: is_excl, rev: is_rev, size: eff_size};

  always_comb begin
    if (is_excl)                           lo_out = '0;
    else if (is_rev && eff_size == SZ_BYTE) lo_out = lo_in ^ LO_ALL;
    else if (is_rev && eff_size == SZ_HALF) lo_out = lo_in ^ LO_HALF;
    else                                   lo_out = lo_in;
  end

  assign eff_addr = {op_addr[ADDR_W-1:LSB_W], lo_out};

  for (genvar g = 0; g < BYTES; g++) begin : g_swap
    assign swapped[8*g +: 8] = op_wdata[8*(BYTES-1-g) +: 8];
  end

  always_comb begin
    for (int i = 0; i < BYTES; i++) begin
      case (eff_size)
        SZ_BYTE: lane_be[i] = (lo_out == LSB_W'(i));
        SZ_HALF: lane_be[i] = (lo_out[LSB_W-1:1] == (LSB_W-1)'(i / 2));
        default: lane_be[i] = 1'b1;
      endcase
    end
  end

  always_comb begin
    case (eff_size)
      SZ_BYTE: lane_wdata = {BYTES{op_wdata[7:0]}};
      SZ_HALF: lane_wdata = {HALFS{op_wdata[15:0]}};
      default: lane_wdata = is_rev ? swapped : op_wdata;
    endcase
  end

endmodule

// File: rtl/excl_load_align.sv
module excl_load_align
  import excl_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  op_attr_t                    attr,
  input  logic [$clog2(DATA_W/8)-1:0] lo,
  input  logic [DATA_W-1:0]           rdata,
  output logic [DATA_W-1:0]           result
);
  localparam int BYTES = DATA_W / 8;
  localparam int LSB_W = $clog2(BYTES);

  logic [DATA_W-1:0] swapped;
  logic [DATA_W-1:0] byte_sh;
  logic [DATA_W-1:0] half_sh;
  logic              attr_unused;

  assign attr_unused = attr.store ^ attr.excl;

  for (genvar g = 0; g < BYTES; g++) begin : g_swap
    assign swapped[8*g +: 8] = rdata[8*(BYTES-1-g) +: 8];
  end

  assign byte_sh = rdata >> {lo, 3'b000};
  assign half_sh = rdata >> {lo[LSB_W-1:1], 4'b0000};

  always_comb begin
    case (attr.size)
      SZ_BYTE: result = {{(DATA_W-8){1'b0}}, byte_sh[7:0]};
      SZ_HALF: result = {{(DATA_W-16){1'b0}}, half_sh[15:0]};
      default: result = attr.rev ? swapped : rdata;
    endcase
  end

endmodule

// File: rtl/excl_resv_track.sv
module excl_resv_track (
  input  logic clk,
  input  logic rst_n,
  input  logic trap_take,
  input  logic st_accept_excl,
  input  logic st_accept_fail,
  input  logic st_write_ok,
  input  logic ld_done_excl,
  input  logic ld_killed,
  output logic resv_q,
  output logic carry_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      resv_q <= 1'b0;
    end else if (trap_take || st_accept_excl) begin
      resv_q <= 1'b0;
    end else if (ld_done_excl && !ld_killed) begin
      resv_q <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      carry_q <= 1'b0;
    end else if (ld_done_excl) begin
      carry_q <= 1'b0;
    end else if (st_accept_fail) begin
      carry_q <= 1'b1;
    end else if (st_write_ok) begin
      carry_q <= 1'b0;
    end
  end

endmodule

// File: rtl/excl_mem_seq.sv
module excl_mem_seq
  import excl_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                op_valid,
  output logic                op_ready,
  input  op_attr_t            dec_attr,
  input  logic [ADDR_W-1:0]   dec_addr,
  input  logic [DATA_W/8-1:0] dec_be,
  input  logic [DATA_W-1:0]   dec_wdata,
  input  logic                resv_q,
  input  logic                trap_take,
  output logic                mem_req_valid,
  input  logic                mem_req_ready,
  output logic                mem_req_write,
  output logic [ADDR_W-1:0]   mem_req_addr,
  output logic [DATA_W/8-1:0] mem_req_be,
  output logic [DATA_W-1:0]   mem_req_wdata,
  input  logic                mem_rsp_valid,
  input  logic [DATA_W-1:0]   mem_rsp_data,
  output logic                res_valid,
  input  logic                res_ready,
  output op_attr_t            cap_attr,
  output logic [DATA_W-1:0]   cap_rdata,
  output logic                st_accept_excl,
  output logic                st_accept_fail,
  output logic                st_write_ok,
  output logic                ld_done_excl,
  output logic                ld_killed
);
  seq_state_e state_q;
  seq_state_e state_d;
  logic [ADDR_W-1:0]   addr_q;
  logic [DATA_W/8-1:0] be_q;
  logic [DATA_W-1:0]   wdata_q;
  logic                kill_q;
  logic                accept;
  logic                resv_live;
  logic                req_fire;
  logic                rsp_take;

  assign op_ready  = (state_q == ST_IDLE);
  assign accept    = op_valid && op_ready;
  assign resv_live = resv_q && !trap_take;
  assign req_fire  = (state_q == ST_REQ) && mem_req_ready;
  assign rsp_take  = (state_q == ST_RSP) && mem_rsp_valid;

  assign st_accept_excl = accept && dec_attr.store && dec_attr.excl;
  assign st_accept_fail = st_accept_excl && !resv_live;
  assign st_write_ok    = req_fire && cap_attr.store && cap_attr.excl;
  assign ld_done_excl   = rsp_take && cap_attr.excl;
  assign ld_killed      = kill_q || trap_take;

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE: if (accept) state_d = st_accept_fail ? ST_IDLE : ST_REQ;
      ST_REQ:  if (mem_req_ready) state_d = cap_attr.store ? ST_IDLE : ST_RSP;
      ST_RSP:  if (mem_rsp_valid) state_d = ST_RES;
      ST_RES:  if (res_ready) state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      cap_attr  <= '0;
      addr_q    <= '0;
      be_q      <= '0;
      wdata_q   <= '0;
      cap_rdata <= '0;
      kill_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      if (accept) begin
        cap_attr <= dec_attr;
        addr_q   <= dec_addr;
        be_q     <= dec_be;
        wdata_q  <= dec_wdata;
        kill_q   <= 1'b0;
      end else if (trap_take && !op_ready) begin
        kill_q <= 1'b1;
      end
      if (rsp_take) cap_rdata <= mem_rsp_data;
    end
  end

  assign mem_req_valid = (state_q == ST_REQ);
  assign mem_req_write = cap_attr.store;
  assign mem_req_addr  = addr_q;
  assign mem_req_be    = be_q;
  assign mem_req_wdata = wdata_q;
  assign res_valid     = (state_q == ST_RES);

endmodule

// File: rtl/excl_access_unit.sv
module excl_access_unit
  import excl_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int DATA_W   = 32,
  parameter int FUNC_W   = 11,
  parameter int EXCL_BIT = 10,
  parameter int REV_BIT  = 9,
  parameter int FLAG_W   = 32,
  parameter int RESV_POS = 24
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                op_valid,
  output logic                op_ready,
  input  logic                op_store,
  input  logic [FUNC_W-1:0]   op_func,
  input  logic [1:0]          op_size,
  input  logic [ADDR_W-1:0]   op_addr,
  input  logic [DATA_W-1:0]   op_wdata,
  input  logic                trap_take,
  output logic                mem_req_valid,
  input  logic                mem_req_ready,
  output logic                mem_req_write,
  output logic [ADDR_W-1:0]   mem_req_addr,
  output logic [DATA_W/8-1:0] mem_req_be,
  output logic [DATA_W-1:0]   mem_req_wdata,
  input  logic                mem_rsp_valid,
  input  logic [DATA_W-1:0]   mem_rsp_data,
  output logic                res_valid,
  input  logic                res_ready,
  output logic [DATA_W-1:0]   res_data,
  output logic                carry_flag,
  output logic [FLAG_W-1:0]   flag_word
);
  localparam int BYTES = DATA_W / 8;
  localparam int LSB_W = $clog2(BYTES);

  op_attr_t            dec_attr;
  logic [ADDR_W-1:0]   dec_addr;
  logic [BYTES-1:0]    dec_be;
  logic [DATA_W-1:0]   dec_wdata;
  op_attr_t            cap_attr;
  logic [DATA_W-1:0]   cap_rdata;
  logic                resv_q;
  logic                carry_q;
  logic                st_accept_excl;
  logic                st_accept_fail;
  logic                st_write_ok;
  logic                ld_done_excl;
  logic                ld_killed;

  excl_decode #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .FUNC_W(FUNC_W),
    .EXCL_BIT(EXCL_BIT), .REV_BIT(REV_BIT)
  ) u_decode (
    .op_store  (op_store),
    .op_func   (op_func),
    .op_size   (op_size),
    .op_addr   (op_addr),
    .op_wdata  (op_wdata),
    .attr      (dec_attr),
    .eff_addr  (dec_addr),
    .lane_be   (dec_be),
    .lane_wdata(dec_wdata)
  );

  excl_mem_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_seq (
    .clk           (clk),
    .rst_n         (rst_n),
    .op_valid      (op_valid),
    .op_ready      (op_ready),
    .dec_attr      (dec_attr),
    .dec_addr      (dec_addr),
    .dec_be        (dec_be),
    .dec_wdata     (dec_wdata),
    .resv_q        (resv_q),
    .trap_take     (trap_take),
    .mem_req_valid (mem_req_valid),
    .mem_req_ready (mem_req_ready),
    .mem_req_write (mem_req_write),
    .mem_req_addr  (mem_req_addr),
    .mem_req_be    (mem_req_be),
    .mem_req_wdata (mem_req_wdata),
    .mem_rsp_valid (mem_rsp_valid),
    .mem_rsp_data  (mem_rsp_data),
    .res_valid     (res_valid),
    .res_ready     (res_ready),
    .cap_attr      (cap_attr),
    .cap_rdata     (cap_rdata),
    .st_accept_excl(st_accept_excl),
    .st_accept_fail(st_accept_fail),
    .st_write_ok   (st_write_ok),
    .ld_done_excl  (ld_done_excl),
    .ld_killed     (ld_killed)
  );

  excl_load_align #(.DATA_W(DATA_W)) u_align (
    .attr  (cap_attr),
    .lo    (mem_req_addr[LSB_W-1:0]),
    .rdata (cap_rdata),
    .result(res_data)
  );

  excl_resv_track u_track (
    .clk           (clk),
    .rst_n         (rst_n),
    .trap_take     (trap_take),
    .st_accept_excl(st_accept_excl),
    .st_accept_fail(st_accept_fail),
    .st_write_ok   (st_write_ok),
    .ld_done_excl  (ld_done_excl),
    .ld_killed     (ld_killed),
    .resv_q        (resv_q),
    .carry_q       (carry_q)
  );

  assign carry_flag = carry_q;

  always_comb begin
    flag_word           = '0;
    flag_word[RESV_POS] = resv_q;
  end

endmodule

// File: rtl/excl_access_unit_chk.sv
module excl_access_unit_chk #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input logic                clk,
  input logic                rst_n,
  input logic                op_valid,
  input logic                op_ready,
  input logic                op_store,
  input logic                op_excl,
  input logic                trap_take,
  input logic                resv_bit,
  input logic                carry_flag,
  input logic                mem_req_valid,
  input logic                mem_req_ready,
  input logic                mem_req_write,
  input logic [ADDR_W-1:0]   mem_req_addr,
  input logic [DATA_W/8-1:0] mem_req_be,
  input logic [DATA_W-1:0]   mem_req_wdata,
  input logic                res_valid,
  input logic                res_ready,
  input logic [DATA_W-1:0]   res_data
);
  logic acc;
  assign acc = op_valid && op_ready;

  // R3
  excl_load_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc && op_excl && !op_store |=> mem_req_valid && !mem_req_write &&
      mem_req_addr[1:0] == 2'b00 && mem_req_be == '1);

  // R5
  excl_store_ok_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc && op_excl && op_store && resv_bit && !trap_take |=> mem_req_valid && mem_req_write);

  // R6
  excl_store_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc && op_excl && op_store && !resv_bit |=> carry_flag && !mem_req_valid && op_ready);

  // R7
  excl_store_consume_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc && op_excl && op_store |=> !resv_bit);

  // R8
  trap_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trap_take |=> !resv_bit);

  // R10
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr) &&
      $stable(mem_req_be) && $stable(mem_req_wdata) && $stable(mem_req_write));

  // R10
  res_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && !res_ready |=> res_valid && $stable(res_data));

endmodule

bind excl_access_unit excl_access_unit_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .op_valid     (op_valid),
  .op_ready     (op_ready),
  .op_store     (op_store),
  .op_excl      (op_func[EXCL_BIT]),
  .trap_take    (trap_take),
  .resv_bit     (flag_word[RESV_POS]),
  .carry_flag   (carry_flag),
  .mem_req_valid(mem_req_valid),
  .mem_req_ready(mem_req_ready),
  .mem_req_write(mem_req_write),
  .mem_req_addr (mem_req_addr),
  .mem_req_be   (mem_req_be),
  .mem_req_wdata(mem_req_wdata),
  .res_valid    (res_valid),
  .res_ready    (res_ready),
  .res_data     (res_data)
);

// File: tb/excl_access_unit_test.sv
`timescale 1ns/1ps
module excl_access_unit_test;
  localparam logic [10:0] F_PLAIN = 11'h000;
  localparam logic [10:0] F_EXCL  = 11'h400;
  localparam logic [10:0] F_REV   = 11'h200;
  localparam logic [31:0] RESV_M  = 32'h0100_0000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        op_valid = 1'b0;
  logic        op_ready;
  logic        op_store = 1'b0;
  logic [10:0] op_func = '0;
  logic [1:0]  op_size = 2'd2;
  logic [31:0] op_addr = '0;
  logic [31:0] op_wdata = '0;
  logic        trap_take = 1'b0;
  logic        mem_req_valid;
  logic        mem_req_ready = 1'b1;
  logic        mem_req_write;
  logic [31:0] mem_req_addr;
  logic [3:0]  mem_req_be;
  logic [31:0] mem_req_wdata;
  logic        mem_rsp_valid = 1'b0;
  logic [31:0] mem_rsp_data = '0;
  logic        res_valid;
  logic        res_ready = 1'b1;
  logic [31:0] res_data;
  logic        carry_flag;
  logic [31:0] flag_word;

  always #2 clk = ~clk;

  excl_access_unit uut (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_ready(op_ready),
    .op_store(op_store), .op_func(op_func), .op_size(op_size), .op_addr(op_addr),
    .op_wdata(op_wdata), .trap_take(trap_take), .mem_req_valid(mem_req_valid),
    .mem_req_ready(mem_req_ready), .mem_req_write(mem_req_write),
    .mem_req_addr(mem_req_addr), .mem_req_be(mem_req_be), .mem_req_wdata(mem_req_wdata),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data), .res_valid(res_valid),
    .res_ready(res_ready), .res_data(res_data), .carry_flag(carry_flag),
    .flag_word(flag_word)
  );

  logic [31:0] mem [16];
  int          wr_cnt = 0;
  int          req_cnt = 0;
  logic [31:0] last_addr = '0;
  logic [3:0]  last_be = '0;
  logic        rsp_pend = 1'b0;
  logic [31:0] rsp_word = '0;
  int          checks = 0;
  int          fails = 0;

  // memory model, evaluated 1 ns after the falling edge when inputs are settled
  always @(posedge clk) begin
    #3;
    if (rsp_pend) begin
      mem_rsp_valid = 1'b1;
      mem_rsp_data  = rsp_word;
      rsp_pend      = 1'b0;
    end else begin
      mem_rsp_valid = 1'b0;
    end
    if (mem_req_valid && mem_req_ready) begin
      req_cnt++;
      last_addr = mem_req_addr;
      last_be   = mem_req_be;
      if (mem_req_write) begin
        wr_cnt++;
        for (int b = 0; b < 4; b++)
          if (mem_req_be[b]) mem[mem_req_addr[5:2]][8*b +: 8] = mem_req_wdata[8*b +: 8];
      end else begin
        rsp_pend = 1'b1;
        rsp_word = mem[mem_req_addr[5:2]];
      end
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wait_idle();
    for (int n = 0; n < 64 && !op_ready; n++) @(negedge clk);
    check("R10 op_ready returns", {31'd0, op_ready}, 32'd1);
  endtask

  task automatic wait_res();
    for (int n = 0; n < 64 && !res_valid; n++) @(negedge clk);
    check("R10 result arrives", {31'd0, res_valid}, 32'd1);
  endtask

  task automatic send(input logic st, input logic [10:0] fn, input logic [1:0] sz,
                      input logic [31:0] ad, input logic [31:0] wd);
    wait_idle();
    op_valid = 1'b1; op_store = st; op_func = fn; op_size = sz;
    op_addr = ad; op_wdata = wd;
    @(posedge clk);
    @(negedge clk);
    op_valid = 1'b0;
  endtask

  task automatic do_op(input logic st, input logic [10:0] fn, input logic [1:0] sz,
                       input logic [31:0] ad, input logic [31:0] wd, output logic [31:0] rd);
    rd = '0;
    send(st, fn, sz, ad, wd);
    if (!st) begin
      wait_res();
      rd = res_data;
      @(posedge clk);
      @(negedge clk);
    end
    wait_idle();
  endtask

  task automatic pulse_trap();
    trap_take = 1'b1;
    @(negedge clk);
    trap_take = 1'b0;
  endtask

  task automatic t_reset();
    check("R1 carry", {31'd0, carry_flag}, 32'd0);
    check("R1 flag_word", flag_word, 32'd0);
    check("R1 op_ready", {31'd0, op_ready}, 32'd1);
    check("R1 mem_req_valid", {31'd0, mem_req_valid}, 32'd0);
    check("R1 res_valid", {31'd0, res_valid}, 32'd0);
  endtask

  task automatic t_store_no_resv();
    int w0 = wr_cnt; int q0 = req_cnt; logic [31:0] rd;
    do_op(1'b1, F_EXCL, 2'd2, 32'h08, 32'hDEAD_0001, rd);
    check("R6 no request", req_cnt - q0, 0);
    check("R6 no write", wr_cnt - w0, 0);
    check("R6 carry set", {31'd0, carry_flag}, 32'd1);
    check("R6 memory kept", mem[2], 32'hC0DE_0002);
  endtask

  task automatic t_reserve_pair();
    int w0; logic [31:0] rd;
    do_op(1'b0, F_EXCL, 2'd0, 32'h13, 32'h0, rd);
    check("R3 aligned addr", last_addr, 32'h10);
    check("R3 word enables", {28'd0, last_be}, 32'hF);
    check("R3 word data", rd, 32'hC0DE_0004);
    check("R4 carry cleared", {31'd0, carry_flag}, 32'd0);
    check("R4 reservation set", flag_word, RESV_M);
    w0 = wr_cnt;
    do_op(1'b1, F_EXCL, 2'd1, 32'h12, 32'h1122_3344, rd);
    check("R5 one write", wr_cnt - w0, 1);
    check("R5 memory", mem[4], 32'h1122_3344);
    check("R3 store aligned", last_addr, 32'h10);
    check("R5 carry clear", {31'd0, carry_flag}, 32'd0);
    check("R7 consumed", flag_word, 32'd0);
    w0 = wr_cnt;
    do_op(1'b1, F_EXCL, 2'd2, 32'h10, 32'h5566_7788, rd);
    check("R7 second no write", wr_cnt - w0, 0);
    check("R7 second carry", {31'd0, carry_flag}, 32'd1);
    check("R7 memory kept", mem[4], 32'h1122_3344);
  endtask

  task automatic t_set_timing();
    logic [31:0] a0;
    mem_req_ready = 1'b0;
    send(1'b0, F_EXCL, 2'd2, 32'h22, 32'h0);
    check("R4 not set at accept", flag_word, 32'd0);
    check("R4 carry kept at accept", {31'd0, carry_flag}, 32'd1);
    a0 = mem_req_addr;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      check("R10 req held", {31'd0, mem_req_valid}, 32'd1);
      check("R10 addr held", mem_req_addr, a0);
    end
    check("R3 addr while held", a0, 32'h20);
    mem_req_ready = 1'b1;
    wait_res();
    check("R4 set at response", flag_word, RESV_M);
    check("R4 carry at response", {31'd0, carry_flag}, 32'd0);
    @(posedge clk);
    @(negedge clk);
    wait_idle();
  endtask

  task automatic t_traps();
    int w0; logic [31:0] rd;
    pulse_trap();
    check("R8 trap clears", flag_word, 32'd0);
    w0 = wr_cnt;
    do_op(1'b1, F_EXCL, 2'd2, 32'h20, 32'h9999_0000, rd);
    check("R8 store after trap", wr_cnt - w0, 0);
    check("R8 carry after trap", {31'd0, carry_flag}, 32'd1);
    mem_req_ready = 1'b0;
    send(1'b0, F_EXCL, 2'd2, 32'h24, 32'h0);
    pulse_trap();
    mem_req_ready = 1'b1;
    wait_res();
    @(posedge clk);
    @(negedge clk);
    wait_idle();
    check("R8 inflight cancel", flag_word, 32'd0);
    check("R4 carry inflight load", {31'd0, carry_flag}, 32'd0);
    w0 = wr_cnt;
    do_op(1'b1, F_EXCL, 2'd2, 32'h24, 32'h7777_0000, rd);
    check("R8 store after cancel", wr_cnt - w0, 0);
  endtask

  task automatic t_plain();
    int w0; logic [31:0] rd;
    do_op(1'b0, F_EXCL, 2'd2, 32'h00, 32'h0, rd);
    w0 = wr_cnt;
    do_op(1'b1, F_PLAIN, 2'd2, 32'h1C, 32'hCAFE_F00D, rd);
    check("R9 plain store writes", wr_cnt - w0, 1);
    check("R9 resv kept store", flag_word, RESV_M);
    check("R9 carry kept store", {31'd0, carry_flag}, 32'd0);
    do_op(1'b0, F_PLAIN, 2'd2, 32'h1C, 32'h0, rd);
    check("R9 plain load data", rd, 32'hCAFE_F00D);
    check("R9 resv kept load", flag_word, RESV_M);
    check("R9 carry kept load", {31'd0, carry_flag}, 32'd0);
    pulse_trap();
    do_op(1'b1, F_EXCL, 2'd2, 32'h18, 32'h0, rd);
    do_op(1'b1, F_PLAIN, 2'd2, 32'h18, 32'h0BAD_0BAD, rd);
    do_op(1'b0, F_PLAIN, 2'd2, 32'h18, 32'h0, rd);
    check("R9 carry one kept", {31'd0, carry_flag}, 32'd1);
    check("R9 resv zero kept", flag_word, 32'd0);
  endtask

  task automatic t_lanes();
    logic [31:0] rd;
    do_op(1'b1, F_REV, 2'd2, 32'h20, 32'h0102_0304, rd);
    check("R2 reversed store", mem[8], 32'h0403_0201);
    check("R2 rev not exclusive", {31'd0, carry_flag}, 32'd1);
    do_op(1'b0, F_REV, 2'd2, 32'h20, 32'h0, rd);
    check("R2 reversed load", rd, 32'h0102_0304);
    do_op(1'b0, F_PLAIN, 2'd2, 32'h20, 32'h0, rd);
    check("R2 plain load", rd, 32'h0403_0201);
    do_op(1'b1, F_PLAIN, 2'd0, 32'h25, 32'h0000_00AB, rd);
    check("R11 byte addr", last_addr, 32'h25);
    check("R11 byte be", {28'd0, last_be}, 32'h2);
    check("R11 byte mem", mem[9], 32'hC0DE_AB09);
    do_op(1'b1, F_REV, 2'd0, 32'h25, 32'h0000_005A, rd);
    check("R2 rev byte addr", last_addr, 32'h26);
    check("R2 rev byte be", {28'd0, last_be}, 32'h4);
    check("R2 rev byte mem", mem[9], 32'hC05A_AB09);
    do_op(1'b0, F_PLAIN, 2'd1, 32'h26, 32'h0, rd);
    check("R11 half load", rd, 32'h0000_C05A);
    check("R11 half be", {28'd0, last_be}, 32'hC);
    do_op(1'b0, F_REV, 2'd1, 32'h24, 32'h0, rd);
    check("R2 rev half addr", last_addr, 32'h26);
    check("R2 rev half load", rd, 32'h0000_C05A);
    do_op(1'b0, F_PLAIN, 2'd0, 32'h25, 32'h0, rd);
    check("R11 byte load", rd, 32'h0000_00AB);
    check("R9 carry after lanes", {31'd0, carry_flag}, 32'd1);
  endtask

  task automatic t_res_hold();
    logic [31:0] d0;
    res_ready = 1'b0;
    send(1'b0, F_PLAIN, 2'd2, 32'h04, 32'h0);
    wait_res();
    d0 = res_data;
    check("R10 result data", d0, 32'hC0DE_0001);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      check("R10 result held", {31'd0, res_valid}, 32'd1);
      check("R10 data held", res_data, d0);
    end
    res_ready = 1'b1;
    @(negedge clk);
    check("R10 result released", {31'd0, res_valid}, 32'd0);
    check("R10 ready after release", {31'd0, op_ready}, 32'd1);
  endtask

  initial begin
    for (int i = 0; i < 16; i++) mem[i] = 32'hC0DE_0000 + i;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_store_no_resv();
    t_reserve_pair();
    t_set_timing();
    t_traps();
    t_plain();
    t_lanes();
    t_res_hold();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule